// File: doc/BRIEF.md
# ADC Conversion Scheduler with Periodic Top-Channel Slot

The scheduler walks an eight-channel enable mask and drives a plain request/done handshake towards an analog conversion core. One sequence begins on a software start pulse when hardware triggering is off, or on a hardware trigger pulse when it is on. Every sequence first waits a programmable warm-up time. Before each channel is requested, a programmable settling (tracking) time must also pass. Channels are converted one after another in ascending index order. Each result is stored in that channel's own data register and also in a shared most-recent-result register, which records the channel index as well. A sticky per-channel end-of-conversion flag is set with each result. The flag clears when software strobes a read of that channel.

The top channel (index 7) can take part in every sequence like the others. As an option, in hardware-trigger mode it can run on its own slower cadence. A 16-bit counter counts the accepted hardware triggers, and channel 7 joins only every Nth sequence. Its result still lands in both its own register and the most-recent register, so it reaches the same downstream path as the others.

The controller has four states. `S_IDLE` waits for an accepted start. `S_WARM` spends the warm-up time. `S_TRACK` spends the settling time. `S_CONV` holds the request until the core reports done. The transitions are:
- IDLE→WARM: a start is accepted with a non-empty effective mask.
- WARM→TRACK: the warm-up expires.
- TRACK→CONV: the settling time expires.
- CONV→TRACK: done arrives and channels remain.
- CONV→IDLE: done arrives for the final channel.

Top module: `adc_seq_sched`

## Requirements
- R1: After reset, `busy`=0, `adc_req`=0, all `eoc` bits are 0, all data registers are 0, and `last_data`=0.
- R2: Only channels whose bit is set in the effective mask are requested, once each per sequence, in ascending index order.
- R3: After the clock edge that accepts a start, `adc_req` first goes high on edge number `startup_cyc`+`track_cyc`+2. After the edge that samples `adc_done`, the next request goes high on edge number `track_cyc`+1.
- R4: `sw_start` starts a sequence only while `hw_trig_en`=0. `hw_trig` starts one only while `hw_trig_en`=1. Otherwise the pulse has no effect.
- R5: A start pulse that arrives while `busy`=1 is ignored. It neither extends nor repeats the running sequence.
- R6: A finished conversion writes its data into its channel register and into `last_data`. It also puts its index into `last_ch` and sets its `eoc` bit.
- R7: An `eoc` bit stays set until `data_rd` has a 1 in that bit position, and then it clears. If a write to that channel falls in the same cycle as the read, the bit stays set.
- R8: A software start converts channel 7 whenever `chan_en[7]`=1, whatever the setting of `last_own_en`.
- R9: With `hw_trig_en`=1 and `last_own_en`=0, channel 7 (if enabled) is converted in every triggered sequence.
- R10: With `hw_trig_en`=1 and `last_own_en`=1, an enabled channel 7 is converted only on every `last_period`-th accepted trigger. A value of 0 counts as 1, and counting starts from reset. The result goes to both its own register and `last_data`.
- R11: A start whose effective mask is empty leaves the block idle and requests nothing. An accepted trigger of that kind still advances the channel-7 period count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_en | input | 8 | Channel enable mask |
| hw_trig_en | input | 1 | 1 = hardware trigger mode, 0 = software start mode |
| last_own_en | input | 1 | Channel 7 runs on its own trigger period |
| sw_start | input | 1 | Software start pulse |
| hw_trig | input | 1 | Hardware trigger pulse |
| startup_cyc | input | 8 | Warm-up wait in cycles |
| track_cyc | input | 8 | Settling wait in cycles |
| last_period | input | 16 | Channel 7 period in accepted triggers |
| data_rd | input | 8 | Per-channel read strobes that clear `eoc` |
| adc_req | output | 1 | Conversion request, held until done |
| adc_ch | output | 3 | Channel being requested |
| adc_done | input | 1 | One-cycle completion pulse from the core |
| adc_data | input | 12 | Conversion result, valid with `adc_done` |
| busy | output | 1 | Sequence in progress |
| ch_data | output | 96 | Per-channel data registers, channel k at bits [12k+11:12k] |
| eoc | output | 8 | Sticky end-of-conversion flags |
| last_data | output | 12 | Most recent result |
| last_ch | output | 3 | Channel of the most recent result |

## Verification
A result being stored for channel k and software strobing the read of channel k can land in the same clock cycle. The bench sets the flag of channel 0 beforehand and runs a one-channel sequence. It watches at each falling edge for the core's done pulse and raises `data_rd[0]` on that same falling edge, so that the write and the read clear are sampled by one rising edge. It then expects the flag still set with the new data in place, and checks that a later lone read does clear it.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_WARM  = 2'd1,
        S_TRACK = 2'd2,
        S_CONV  = 2'd3
    } seq_state_e;
endpackage

// File: rtl/adc_dly_timer.sv
module adc_dly_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          zero
);
    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/adc_lowest_pick.sv
module adc_lowest_pick #(
    parameter int NCH = 8,
    localparam int IW = $clog2(NCH)
) (
    input  logic [NCH-1:0] mask,
    output logic [IW-1:0]  idx
);
    always_comb begin
        idx = '0;
        for (int k = NCH - 1; k >= 0; k--) begin
            if (mask[k]) idx = IW'(k);
        end
    end
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
    parameter int NCH = 8,
    parameter int DW  = 12,
    localparam int IW = $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IW-1:0]     wr_idx,
    input  logic [DW-1:0]     wr_data,
    input  logic [NCH-1:0]    rd_strobe,
    output logic [NCH*DW-1:0] ch_data,
    output logic [NCH-1:0]    eoc,
    output logic [DW-1:0]     last_data,
    output logic [IW-1:0]     last_ch
);
    for (genvar i = 0; i < NCH; i++) begin : g_chan
        logic [DW-1:0] data_q;
        logic          flag_q;
        logic          hit;

        assign hit = wr_en && (wr_idx == IW'(i));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                data_q <= '0;
                flag_q <= 1'b0;
            end else begin
                if (hit) data_q <= wr_data;
                if (hit)               flag_q <= 1'b1;
                else if (rd_strobe[i]) flag_q <= 1'b0;
            end
        end

        assign ch_data[i*DW +: DW] = data_q;
        assign eoc[i]              = flag_q;

        a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_q && !rd_strobe[i]) |=> flag_q);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_data <= '0;
            last_ch   <= '0;
        end else if (wr_en) begin
            last_data <= wr_data;
            last_ch   <= wr_idx;
        end
    end

    a_r6_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> eoc[$past(wr_idx)]);
    a_r6_last_copy: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (last_data == $past(wr_data)));
endmodule

// File: rtl/adc_seq_sched.sv
module adc_seq_sched
    import adc_seq_pkg::*;
#(
    parameter int NCH = 8,
    parameter int DW  = 12,
    parameter int TW  = 8,
    parameter int PW  = 16,
    localparam int IW   = $clog2(NCH),
    localparam int LAST = NCH - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    chan_en,
    input  logic              hw_trig_en,
    input  logic              last_own_en,
    input  logic              sw_start,
    input  logic              hw_trig,
    input  logic [TW-1:0]     startup_cyc,
    input  logic [TW-1:0]     track_cyc,
    input  logic [PW-1:0]     last_period,
    input  logic [NCH-1:0]    data_rd,
    output logic              adc_req,
    output logic [IW-1:0]     adc_ch,
    input  logic              adc_done,
    input  logic [DW-1:0]     adc_data,
    output logic              busy,
    output logic [NCH*DW-1:0] ch_data,
    output logic [NCH-1:0]    eoc,
    output logic [DW-1:0]     last_data,
    output logic [IW-1:0]     last_ch
);
    seq_state_e     state_q, state_d;
    logic [NCH-1:0] seq_mask_q, start_mask, cur_oh, mask_after;
    logic [PW-1:0]  lc_cnt_q;
    logic           accept, per_acc, last_due, wr_en;
    logic           tmr_load, tmr_zero;
    logic [TW-1:0]  tmr_val;

    // start qualification and channel-7 cadence
    assign accept   = (state_q == S_IDLE) && (hw_trig_en ? hw_trig : sw_start);
    assign per_acc  = accept && hw_trig_en && last_own_en;
    assign last_due = ({1'b0, lc_cnt_q} + (PW+1)'(1)) >= {1'b0, last_period};

    always_comb begin
        start_mask = chan_en;
        if (hw_trig_en && last_own_en)
            start_mask[LAST] = chan_en[LAST] && last_due;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            lc_cnt_q <= '0;
        else if (per_acc)
            lc_cnt_q <= last_due ? '0 : lc_cnt_q + 1'b1;
    end

    adc_lowest_pick #(.NCH(NCH)) u_pick (
        .mask (seq_mask_q),
        .idx  (adc_ch)
    );

    assign cur_oh     = NCH'(1) << adc_ch;
    assign mask_after = seq_mask_q & ~cur_oh;
    assign wr_en      = (state_q == S_CONV) && adc_done;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (accept && (start_mask != '0)) state_d = S_WARM;
            S_WARM:  if (tmr_zero) state_d = S_TRACK;
            S_TRACK: if (tmr_zero) state_d = S_CONV;
            S_CONV:  if (adc_done) state_d = (mask_after != '0) ? S_TRACK : S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // state register and sequence mask
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= S_IDLE;
            seq_mask_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == S_IDLE && accept)
                seq_mask_q <= start_mask;
            else if (wr_en)
                seq_mask_q <= mask_after;
        end
    end

    // outputs and timer control
    always_comb begin
        adc_req  = (state_q == S_CONV);
        busy     = (state_q != S_IDLE);
        tmr_load = (state_d == S_WARM  && state_q == S_IDLE) ||
                   (state_d == S_TRACK && state_q != S_TRACK);
        tmr_val  = (state_q == S_IDLE) ? startup_cyc : track_cyc;
    end

    adc_dly_timer #(.TW(TW)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    adc_result_bank #(.NCH(NCH), .DW(DW)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_idx    (adc_ch),
        .wr_data   (adc_data),
        .rd_strobe (data_rd),
        .ch_data   (ch_data),
        .eoc       (eoc),
        .last_data (last_data),
        .last_ch   (last_ch)
    );

    a_r2_req_in_mask: assert property (@(posedge clk) disable iff (!rst_n)
        adc_req |-> seq_mask_q[adc_ch]);
    a_r4_sw_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && hw_trig_en && !hw_trig) |=> (state_q == S_IDLE));
    a_r5_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !wr_en) |=> $stable(seq_mask_q));
    a_r11_empty_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && start_mask == '0) |=> (state_q == S_IDLE));
endmodule

// File: tb/tb_adc_seq_sched.sv
module tb_adc_seq_sched;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  chan_en = '0;
    logic        hw_trig_en = 1'b0, last_own_en = 1'b0, sw_start = 1'b0, hw_trig = 1'b0;
    logic [7:0]  startup_cyc = 8'd3, track_cyc = 8'd2;
    logic [15:0] last_period = 16'd0;
    logic [7:0]  data_rd = '0;
    logic        adc_req, busy, adc_done;
    logic [2:0]  adc_ch, last_ch;
    logic [11:0] adc_data, last_data;
    logic [95:0] ch_data;
    logic [7:0]  eoc;

    int checks = 0, errors = 0;
    int cyc = 0, dn_cyc = 0, lg_n = 0;
    int lg[16];
    int gap[16];
    logic [11:0] exp_d[8];
    logic req_d = 1'b0;

    always #10 clk = ~clk;

    adc_seq_sched dut (
        .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .hw_trig_en(hw_trig_en),
        .last_own_en(last_own_en), .sw_start(sw_start), .hw_trig(hw_trig),
        .startup_cyc(startup_cyc), .track_cyc(track_cyc), .last_period(last_period),
        .data_rd(data_rd), .adc_req(adc_req), .adc_ch(adc_ch), .adc_done(adc_done),
        .adc_data(adc_data), .busy(busy), .ch_data(ch_data), .eoc(eoc),
        .last_data(last_data), .last_ch(last_ch)
    );

    // behavioural conversion core
    logic       pend;
    logic [2:0] lat;
    logic [8:0] conv_n;
    always @(posedge clk) begin
        if (!rst_n) begin
            pend <= 1'b0; lat <= '0; adc_done <= 1'b0; adc_data <= '0; conv_n <= '0;
        end else begin
            adc_done <= 1'b0;
            if (pend) begin
                if (lat == 3'd1) begin
                    adc_done <= 1'b1;
                    adc_data <= {adc_ch, conv_n};
                    conv_n   <= conv_n + 1'b1;
                    pend     <= 1'b0;
                end
                lat <= lat - 1'b1;
            end else if (adc_req && !adc_done) begin
                pend <= 1'b1;
                lat  <= 3'd3;
            end
        end
    end

    // request and result monitor
    always @(negedge clk) begin
        cyc++;
        if (adc_req && !req_d && lg_n < 16) begin
            lg[lg_n]  = int'(adc_ch);
            gap[lg_n] = cyc - dn_cyc;
            lg_n++;
        end
        req_d = adc_req;
        if (adc_done) begin
            dn_cyc = cyc;
            exp_d[adc_ch] = adc_data;
        end
    end

    function automatic logic [11:0] chd(input int c);
        return ch_data[c*12 +: 12];
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        lg_n = 0;
    endtask

    task automatic pulse_sw();
        @(negedge clk) sw_start = 1'b1;
        @(negedge clk) sw_start = 1'b0;
    endtask

    task automatic pulse_hw();
        @(negedge clk) hw_trig = 1'b1;
        @(negedge clk) hw_trig = 1'b0;
    endtask

    task automatic wait_idle();
        int n = 0;
        while (busy && n < 500) begin
            @(negedge clk);
            n++;
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        chk(busy == 0 && adc_req == 0, "R1 idle", int'(busy), 0);
        chk(eoc == 0, "R1 eoc", int'(eoc), 0);
        chk(ch_data == '0 && last_data == 0, "R1 data", int'(last_data), 0);
    endtask

    task automatic t_sw_sequence();
        int n;
        do_reset();
        chan_en = 8'b1010_0101; hw_trig_en = 0; last_own_en = 1;
        @(negedge clk) sw_start = 1'b1;
        @(negedge clk) sw_start = 1'b0;
        n = 1;
        while (!adc_req && n < 100) begin
            @(negedge clk);
            n++;
        end
        chk(n == 3 + 2 + 3, "R3 first request delay", n, 8);
        wait_idle();
        chk(lg_n == 4, "R2 request count", lg_n, 4);
        chk(lg[0] == 0 && lg[1] == 2 && lg[2] == 5 && lg[3] == 7, "R2 ascending order",
            lg[1] * 100 + lg[2] * 10 + lg[3], 257);
        chk(gap[1] == 2 + 2, "R3 settling gap", gap[1], 4);
        chk(lg[3] == 7, "R8 ch7 with software start", lg[3], 7);
        chk(eoc == 8'b1010_0101, "R6 eoc flags", int'(eoc), 8'hA5);
        chk(chd(7) == exp_d[7] && chd(2) == exp_d[2], "R6 channel data", int'(chd(7)), int'(exp_d[7]));
        chk(last_data == exp_d[7] && last_ch == 7, "R6 last data", int'(last_ch), 7);
    endtask

    task automatic t_eoc_clear();
        @(negedge clk) data_rd = 8'b0000_0100;
        @(negedge clk) data_rd = 8'h00;
        chk(eoc == 8'b1010_0001, "R7 read clears one flag", int'(eoc), 8'hA1);
        chan_en = 8'h01; lg_n = 0;
        pulse_sw();
        while (!adc_done) @(negedge clk);
        data_rd = 8'h01;
        @(negedge clk) data_rd = 8'h00;
        chk(eoc[0] == 1, "R7 write beats read", int'(eoc[0]), 1);
        chk(chd(0) == exp_d[0], "R7 new data stored", int'(chd(0)), int'(exp_d[0]));
        wait_idle();
        @(negedge clk) data_rd = 8'h01;
        @(negedge clk) data_rd = 8'h00;
        chk(eoc[0] == 0, "R7 lone read clears", int'(eoc[0]), 0);
    endtask

    task automatic t_ignore();
        chan_en = 8'h0F; hw_trig_en = 0; lg_n = 0;
        pulse_hw();
        repeat (3) @(negedge clk);
        chk(busy == 0 && lg_n == 0, "R4 hw trigger ignored in software mode", lg_n, 0);
        hw_trig_en = 1;
        pulse_sw();
        repeat (3) @(negedge clk);
        chk(busy == 0 && lg_n == 0, "R4 software start ignored in hardware mode", lg_n, 0);
        pulse_hw();
        repeat (8) @(negedge clk);
        pulse_hw();
        wait_idle();
        repeat (5) @(negedge clk);
        chk(lg_n == 4 && busy == 0, "R5 trigger while busy ignored", lg_n, 4);
    endtask

    task automatic t_hw_every();
        chan_en = 8'h81; hw_trig_en = 1; last_own_en = 0; lg_n = 0;
        pulse_hw();
        wait_idle();
        chk(lg_n == 2 && lg[1] == 7, "R9 ch7 in every triggered sequence", lg_n, 2);
        chk(last_ch == 7 && chd(7) == exp_d[7], "R9 ch7 result", int'(last_ch), 7);
    endtask

    task automatic t_last_period();
        do_reset();
        chan_en = 8'h83; hw_trig_en = 1; last_own_en = 1; last_period = 16'd3;
        for (int k = 1; k <= 4; k++) begin
            lg_n = 0;
            pulse_hw();
            wait_idle();
            if (k == 3) begin
                chk(lg_n == 3 && lg[2] == 7, "R10 ch7 on third trigger", lg_n, 3);
                chk(eoc[7] == 1 && chd(7) == exp_d[7] && last_data == exp_d[7],
                    "R10 ch7 writes both registers", int'(last_data), int'(exp_d[7]));
            end else begin
                chk(lg_n == 2 && eoc[7] == (k == 4), "R10 ch7 skipped", lg_n, 2);
            end
        end
        chk(last_ch == 1, "R10 last channel after skip", int'(last_ch), 1);
        chan_en = 8'h80; lg_n = 0;
        pulse_hw();
        wait_idle();
        chk(lg_n == 0 && busy == 0, "R11 empty mask stays idle", lg_n, 0);
        pulse_hw();
        wait_idle();
        chk(lg_n == 1 && lg[0] == 7, "R11 empty trigger still counted", lg_n, 1);
        hw_trig_en = 0; lg_n = 0;
        pulse_sw();
        wait_idle();
        chk(lg_n == 1 && lg[0] == 7, "R8 software start ignores period", lg_n, 1);
        chan_en = 8'h00; lg_n = 0;
        pulse_sw();
        repeat (4) @(negedge clk);
        chk(lg_n == 0 && busy == 0, "R11 empty software start", lg_n, 0);
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_sw_sequence();
        t_eoc_clear();
        t_ignore();
        t_hw_every();
        t_last_period();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule